// File: doc/BRIEF.md
# NAND Page ECC Syndrome Classifier

This block takes the three-byte check code stored alongside a 256-byte flash segment and the three-byte code recomputed from the data as read back. It folds them into a 24-bit syndrome and decides what went wrong. The result is one of four outcomes: the codes agree; one data bit flipped, with its position given; one bit of the stored code itself flipped; or the damage is beyond single-bit repair.

The caller applies the bit flip to its own buffer, using the reported byte offset and bit number. A mode input selects which of the two low code bytes holds the high half of the line parity, so either byte layout of the stored code can be handled. Codes are captured on a valid strobe. The classification leaves a register stage on the following clock edge, and a one-cycle valid flag marks it. A new pair of codes may be offered on every cycle.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: Code byte k is bits [8k+7:8k] of each code input. The syndrome bytes are the bytewise XOR of the two codes. With `order_alt` = 0, XOR byte 0 becomes s1 and XOR byte 1 becomes s0. With `order_alt` = 1, byte 0 becomes s0 and byte 1 becomes s1. Byte 2 is always s2.
- R2: An all-zero syndrome yields status 00, byte offset 0 and bit number 0.
- R3: The result is status 01 when the syndrome is correctable. That holds when, in both s0 and s1, every bit pair (7,6), (5,4), (3,2), (1,0) holds unequal bits, and in s2 the pairs (7,6), (5,4), (3,2) hold unequal bits.
- R4: For status 01 the byte offset is {s1[7], s1[5], s1[3], s1[1], s0[7], s0[5], s0[3], s0[1]}, most significant bit first.
- R5: For status 01 the bit number is {s2[7], s2[5], s2[3]}, most significant bit first.
- R6: Bits 1 and 0 of s2 change neither the status nor the location of a syndrome that otherwise passes R3.
- R7: A syndrome that fails R3 and has exactly one set bit among its 24 yields status 10, meaning an error in the stored code with no data change.
- R8: Every other nonzero syndrome yields status 11, meaning uncorrectable.
- R9: Byte offset and bit number are 0 whenever the status is not 01.
- R10: Codes presented with `in_valid` high at clock edge k produce their result after edge k+1. `res_valid` is high for that one cycle, and the result outputs hold until the next result.
- R11: While reset is asserted, `res_valid` is 0, the status is 00 and the location outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Capture strobe for the two codes |
| order_alt | input | 1 | Selects the alternate layout of code bytes 0 and 1 |
| calc_code | input | 24 | Code recomputed from the read data |
| read_code | input | 24 | Code stored with the data |
| res_valid | output | 1 | One-cycle flag marking a new result |
| res_status | output | 2 | 00 clean, 01 data bit fixable, 10 stored-code bit, 11 uncorrectable |
| res_byte | output | 8 | Byte offset of the faulty data bit |
| res_bit | output | 3 | Bit number of the faulty data bit |

## Verification
Every one of the 2048 single data-bit positions is injected under both byte layouts. Each case must come back as status 01 with exactly that offset and bit, which separates a correct location extraction from swapped or misaligned syndrome bits. All 24 single stored-code bit flips must give status 10 rather than 01 or 11. Random pairs of data errors and random pairs of code-bit errors must give status 11 with a zero location, which shows that the pair test rejects them.

A data pattern built for one layout but run in the other must report the nibble-swapped offset. Patterns with s2 bits 1 and 0 disturbed must still be located. Together these tell apart a layout multiplexer that is ignored and a pair test that wrongly covers the two unused bits.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
    localparam int BYTE_W   = 8;
    localparam int CODE_BYTES = 3;
    localparam int CODE_W   = BYTE_W * CODE_BYTES;
    localparam int OFFS_W   = 8;
    localparam int BITN_W   = 3;
    localparam int CNT_W    = $clog2(CODE_W + 1);

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_CODE  = 2'b10,
        ST_FATAL = 2'b11
    } ecc_status_e;

    typedef struct packed {
        logic [BYTE_W-1:0] s2;
        logic [BYTE_W-1:0] s1;
        logic [BYTE_W-1:0] s0;
    } syndrome_t;
endpackage

// File: rtl/ecc_syn_form.sv
module ecc_syn_form
    import ecc_syn_pkg::*;
(
    input  logic [CODE_W-1:0] calc_code,
    input  logic [CODE_W-1:0] read_code,
    input  logic              order_alt,
    output syndrome_t         syn
);
    logic [CODE_BYTES-1:0][BYTE_W-1:0] diff;

    for (genvar g = 0; g < CODE_BYTES; g++) begin : g_diff
        assign diff[g] = calc_code[g*BYTE_W +: BYTE_W] ^ read_code[g*BYTE_W +: BYTE_W];
    end

    // Layout select: which low code byte carries the upper line parity.
    always_comb begin
        syn.s2 = diff[2];
        if (order_alt) begin
            syn.s0 = diff[0];
            syn.s1 = diff[1];
        end else begin
            syn.s0 = diff[1];
            syn.s1 = diff[0];
        end
    end
endmodule

// File: rtl/ecc_syn_lane.sv
module ecc_syn_lane #(
    parameter int PAIRS = 4
) (
    input  logic [2*PAIRS-1:0] lane,
    output logic [PAIRS-1:0]   hi_bits,
    output logic               comp_ok
);
    logic [PAIRS-1:0] pair_diff;

    // Each pair (2p+1, 2p) must hold a bit and its complement.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign hi_bits[p]   = lane[2*p+1];
        assign pair_diff[p] = lane[2*p+1] ^ lane[2*p];
    end

    assign comp_ok = &pair_diff;
endmodule

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
    import ecc_syn_pkg::*;
(
    input  syndrome_t   syn,
    input  logic        lanes_ok,
    output ecc_status_e status
);
    logic [CODE_W-1:0] flat;
    logic [CNT_W-1:0]  ones;

    assign flat = syn;

    always_comb begin
        ones = '0;
        for (int i = 0; i < CODE_W; i++) begin
            ones = ones + CNT_W'(flat[i]);
        end
    end

    always_comb begin
        if (flat == '0) begin
            status = ST_CLEAN;
        end else if (lanes_ok) begin
            status = ST_FIXED;
        end else if (ones == CNT_W'(1)) begin
            status = ST_CODE;
        end else begin
            status = ST_FATAL;
        end
    end
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
    import ecc_syn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              order_alt,
    input  logic [CODE_W-1:0] calc_code,
    input  logic [CODE_W-1:0] read_code,
    output logic              res_valid,
    output logic [1:0]        res_status,
    output logic [OFFS_W-1:0] res_byte,
    output logic [BITN_W-1:0] res_bit
);
    localparam int LO_PAIRS = BYTE_W / 2;
    localparam int S2_PAIRS = BITN_W;

    // Capture stage
    logic [CODE_W-1:0] cap_calc;
    logic [CODE_W-1:0] cap_read;
    logic              cap_alt;
    logic              cap_vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_calc <= '0;
            cap_read <= '0;
            cap_alt  <= 1'b0;
            cap_vld  <= 1'b0;
        end else begin
            cap_vld <= in_valid;
            if (in_valid) begin
                cap_calc <= calc_code;
                cap_read <= read_code;
                cap_alt  <= order_alt;
            end
        end
    end

    // Syndrome and per-byte pair tests
    syndrome_t             syn;
    logic [LO_PAIRS-1:0]   hi_s0;
    logic [LO_PAIRS-1:0]   hi_s1;
    logic [S2_PAIRS-1:0]   hi_s2;
    logic                  ok_s0;
    logic                  ok_s1;
    logic                  ok_s2;
    ecc_status_e           status_c;

    ecc_syn_form u_form (
        .calc_code (cap_calc),
        .read_code (cap_read),
        .order_alt (cap_alt),
        .syn       (syn)
    );

    ecc_syn_lane #(.PAIRS(LO_PAIRS)) u_lane_s0 (
        .lane    (syn.s0),
        .hi_bits (hi_s0),
        .comp_ok (ok_s0)
    );

    ecc_syn_lane #(.PAIRS(LO_PAIRS)) u_lane_s1 (
        .lane    (syn.s1),
        .hi_bits (hi_s1),
        .comp_ok (ok_s1)
    );

    // s2 bits 1..0 take no part in the pair test.
    ecc_syn_lane #(.PAIRS(S2_PAIRS)) u_lane_s2 (
        .lane    (syn.s2[BYTE_W-1 -: 2*S2_PAIRS]),
        .hi_bits (hi_s2),
        .comp_ok (ok_s2)
    );

    ecc_syn_classify u_class (
        .syn      (syn),
        .lanes_ok (ok_s0 & ok_s1 & ok_s2),
        .status   (status_c)
    );

    // Result stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_status <= ST_CLEAN;
            res_byte   <= '0;
            res_bit    <= '0;
        end else begin
            res_valid <= cap_vld;
            if (cap_vld) begin
                res_status <= status_c;
                if (status_c == ST_FIXED) begin
                    res_byte <= {hi_s1, hi_s0};
                    res_bit  <= hi_s2;
                end else begin
                    res_byte <= '0;
                    res_bit  <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/ecc_syndrome_corrector_chk.sv
module ecc_syndrome_corrector_chk
    import ecc_syn_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CODE_W-1:0] calc_code,
    input logic [CODE_W-1:0] read_code,
    input logic              res_valid,
    input logic [1:0]        res_status,
    input logic [OFFS_W-1:0] res_byte,
    input logic [BITN_W-1:0] res_bit
);
    // R10
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid, 2));

    // R9
    loc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status != 2'b01) |-> (res_byte == '0 && res_bit == '0));

    // R2
    clean_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'b00) |-> ($past(calc_code, 2) == $past(read_code, 2)));

    // R7
    code_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'b10) |->
            ($countones($past(calc_code, 2) ^ $past(read_code, 2)) == 1));

    // R8
    fatal_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'b11) |->
            ($countones($past(calc_code, 2) ^ $past(read_code, 2)) > 1));

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && res_status == 2'b00));
endmodule

bind ecc_syndrome_corrector ecc_syndrome_corrector_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .calc_code  (calc_code),
    .read_code  (read_code),
    .res_valid  (res_valid),
    .res_status (res_status),
    .res_byte   (res_byte),
    .res_bit    (res_bit)
);

// File: tb/ecc_syndrome_corrector_tb.sv
`timescale 1ns/1ps
module ecc_syndrome_corrector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        order_alt = 1'b0;
    logic [23:0] calc_code = '0;
    logic [23:0] read_code = '0;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [7:0]  res_byte;
    logic [2:0]  res_bit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ecc_syndrome_corrector u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .order_alt(order_alt),
        .calc_code(calc_code), .read_code(read_code), .res_valid(res_valid),
        .res_status(res_status), .res_byte(res_byte), .res_bit(res_bit)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Syndrome bytes {s2,s1,s0} of a single data-bit error (R3..R5 encoding).
    function automatic logic [23:0] data_syn(input logic [7:0] b, input logic [2:0] n);
        logic [7:0] s0, s1, s2;
        for (int i = 0; i < 4; i++) begin
            s1[2*i+1] = b[4+i]; s1[2*i] = ~b[4+i];
            s0[2*i+1] = b[i];   s0[2*i] = ~b[i];
        end
        for (int j = 0; j < 3; j++) begin
            s2[2*j+3] = n[j]; s2[2*j+2] = ~n[j];
        end
        s2[1:0] = 2'b00;
        return {s2, s1, s0};
    endfunction

    // Place syndrome bytes into code byte order for a layout (R1).
    function automatic logic [23:0] place(input logic [23:0] s, input logic alt);
        return alt ? s : {s[23:16], s[7:0], s[15:8]};
    endfunction

    task automatic run(input logic [23:0] c, input logic [23:0] x, input logic alt,
                       input logic [1:0] es, input logic [7:0] eb, input logic [2:0] en,
                       input string req);
        @(negedge clk);
        calc_code = c; read_code = c ^ x; order_alt = alt; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R10 early valid"}, int'(res_valid), 0);
        @(negedge clk);
        chk({req, " R10 valid"}, int'(res_valid), 1);
        chk({req, " status"}, int'(res_status), int'(es));
        chk({req, " byte"}, int'(res_byte), int'(eb));
        chk({req, " bit"}, int'(res_bit), int'(en));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 valid", int'(res_valid), 0);
        chk("R11 status", int'(res_status), 0);
        chk("R11 byte", int'(res_byte), 0);
        chk("R11 bit", int'(res_bit), 0);
        rst_n = 1'b1;

        // R2 zero syndrome
        run(24'h000000, 24'h0, 1'b0, 2'b00, 8'h00, 3'd0, "R2 zero");
        run(24'hA5C3FF, 24'h0, 1'b1, 2'b00, 8'h00, 3'd0, "R2 zero alt");

        // R3 R4 R5 R1: every data bit in both layouts
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 256; b++) begin
                for (int n = 0; n < 8; n++) begin
                    run(24'($urandom), place(data_syn(8'(b), 3'(n)), m[0]), m[0],
                        2'b01, 8'(b), 3'(n), "R3 R4 R5 single data bit");
                end
            end
        end

        // R1 layout mismatch: nibble-swapped offset
        for (int b = 0; b < 256; b += 37) begin
            run(24'($urandom), place(data_syn(8'(b), 3'd5), 1'b0), 1'b1,
                2'b01, {b[3:0], b[7:4]}, 3'd5, "R1 layout swap");
        end

        // R6 s2 low bits ignored
        for (int k = 1; k < 4; k++) begin
            run(24'($urandom), place(data_syn(8'h5A, 3'd6), 1'b0) ^ (24'(k) << 16), 1'b0,
                2'b01, 8'h5A, 3'd6, "R6 s2 low bits");
        end

        // R7 single stored-code bit
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 24; i++) begin
                run(24'($urandom), 24'(1) << i, m[0], 2'b10, 8'h00, 3'd0, "R7 R9 code bit");
            end
        end

        // R8 double data errors
        for (int t = 0; t < 200; t++) begin
            int p, q;
            p = int'($urandom_range(2047));
            q = int'($urandom_range(2047));
            if (q == p) q = (p + 1) % 2048;
            run(24'($urandom),
                place(data_syn(8'(p >> 3), 3'(p)) ^ data_syn(8'(q >> 3), 3'(q)), t[0]),
                t[0], 2'b11, 8'h00, 3'd0, "R8 R9 double data");
        end

        // R8 double code-bit errors
        for (int t = 0; t < 100; t++) begin
            int p, q;
            p = int'($urandom_range(23));
            q = int'($urandom_range(23));
            if (q == p) q = (p + 1) % 24;
            run(24'($urandom), (24'(1) << p) | (24'(1) << q), t[0],
                2'b11, 8'h00, 3'd0, "R8 double code");
        end

        // R10 result held after valid drops
        run(24'h123456, place(data_syn(8'hC3, 3'd2), 1'b0), 1'b0, 2'b01, 8'hC3, 3'd2, "R10 load");
        @(negedge clk);
        chk("R10 valid drops", int'(res_valid), 0);
        chk("R10 byte held", int'(res_byte), 8'hC3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule